// File: doc/BRIEF.md
# Erasable Programmable Byte Memory Model

A synthesizable, clocked model of an ultraviolet-erasable programmable memory of byte-wide words. It serves as a target for programmer and boot-loader logic under test. The model decodes the operating mode from two active-low strobes (chip select and output gate), a flag saying the programming voltage is present, and a flag saying a high voltage sits on address line 9. From that mode it reads a word, programs one, verifies one, or returns one of two fixed identifier bytes.

Programming can only turn ones into zeros. A separate erase strobe starts a sweep that sets every bit back to one, one word per clock. The same sweep runs after reset, so the array comes up blank. Tri-state output is stood in for by a drive flag; when that flag is low, the data bus reads zero.

All inputs are sampled on the rising clock edge. The output pair is registered, so a result appears one cycle after the inputs that asked for it. The word count is `2**ADDR_W`. The default `ADDR_W` of 11 keeps the model small; setting `ADDR_W` to 15 gives the full 32,768-word organisation.

Top module: `otp_eprom_model`

## Requirements
- R1: With `vpp_on`=0, `a9_hv`=0, `ce_n`=0 and `oe_n`=0 (read), the next cycle shows `dout_en`=1 and `dout` equal to the word stored at the sampled `addr`.
- R2: With `vpp_on`=0, `ce_n`=0 and `oe_n`=1 (output off), the next cycle shows `dout_en`=0.
- R3: With `vpp_on`=0 and `ce_n`=1 (standby), the next cycle shows `dout_en`=0 whatever `oe_n` is.
- R4: Whenever `dout_en` is 0, `dout` is 8'h00.
- R5: With `vpp_on`=1 and `oe_n`=1, a low phase of `ce_n` lasting at least one cycle, followed by a cycle with `ce_n`=1, `vpp_on`=1 and `oe_n`=1, programs the word. The word at the address sampled in the last low cycle becomes its old value AND the `din` sampled in that cycle, so bits are only ever cleared.
- R6: If `vpp_on` falls, or `oe_n` goes low, before `ce_n` rises, the pulse writes nothing.
- R7: With `vpp_on`=1, `ce_n`=1 and `oe_n`=0 (verify), the next cycle shows `dout_en`=1 and the stored word at `addr`.
- R8: With `vpp_on`=1 and `oe_n`=1, the next cycle shows `dout_en`=0. With `vpp_on`=1 and both strobes low, `dout_en` is 0 and nothing is written.
- R9: With `a9_hv`=1, `vpp_on`=0 and both strobes low, the next cycle shows `dout_en`=1 and `dout`=8'h20 when `addr[0]`=0, or 8'h8D when `addr[0]`=1.
- R10: An `erase` pulse starts a sweep of `2**ADDR_W` cycles, after which every word reads 8'hFF. During the sweep `dout_en` stays 0, and program pulses and further erase pulses are ignored.
- R11: Reset starts the same sweep, so every word reads 8'hFF once the sweep completes after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst | input | 1 | Synchronous active-high reset; starts the blanking sweep |
| addr | input | ADDR_W | Word address |
| ce_n | input | 1 | Chip select, active low; its low pulse programs |
| oe_n | input | 1 | Output gate, active low |
| vpp_on | input | 1 | Programming voltage present |
| a9_hv | input | 1 | High voltage present on address line 9 (identifier mode) |
| erase | input | 1 | Starts a whole-array blanking sweep |
| din | input | 8 | Data to program |
| dout | output | 8 | Output word; zero when not driven |
| dout_en | output | 1 | Output driven (stands in for the tri-state enable) |

## Verification
The checker watches the strobe decode on every cycle. It confirms that standby, output-off and program or inhibit combinations leave the bus undriven, that an undriven bus reads zero, that nothing is driven while a sweep runs, and that identifier mode returns the byte selected by the low address bit. Stored contents are beyond what a property can see. The AND-only programming, the aborted pulses, the verify of fresh data, and the fact that an erase or a reset leaves the whole array blank are shown only by the bench's scenarios, which compare reads against a shadow array kept from the requirements.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int unsigned WORD_W = 8;
    localparam logic [WORD_W-1:0] ID_MAKER = 8'h20;
    localparam logic [WORD_W-1:0] ID_PART  = 8'h8D;
    localparam logic [WORD_W-1:0] BLANK    = '1;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_OFF,
        M_READ,
        M_IDENT,
        M_PROGRAM,
        M_VERIFY,
        M_INHIBIT
    } otp_mode_e;

    typedef struct packed {
        logic              en;
        logic [WORD_W-1:0] data;
    } otp_drive_t;

    function automatic otp_mode_e decode_mode(input logic ce_n, input logic oe_n,
                                              input logic vpp_on, input logic a9_hv);
        otp_mode_e m;
        if (vpp_on) begin
            if (oe_n) m = ce_n ? M_INHIBIT : M_PROGRAM;
            else      m = ce_n ? M_VERIFY  : M_INHIBIT;
        end else if (ce_n) begin
            m = M_STANDBY;
        end else if (oe_n) begin
            m = M_OFF;
        end else begin
            m = a9_hv ? M_IDENT : M_READ;
        end
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] ident_byte(input logic sel);
        return sel ? ID_PART : ID_MAKER;
    endfunction

endpackage

// File: rtl/otp_cell_array.sv
module otp_cell_array
    import otp_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              erase_req,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_mask,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              busy
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic [WORD_W-1:0] cells [DEPTH];
    logic [ADDR_W-1:0] sweep_ptr;

    // Blanking sweep: one word per cycle, started by reset or erase.
    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b1;
            sweep_ptr <= '0;
        end else if (busy) begin
            if (sweep_ptr == LAST) busy <= 1'b0;
            else                   sweep_ptr <= sweep_ptr + 1'b1;
        end else if (erase_req) begin
            busy      <= 1'b1;
            sweep_ptr <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst) begin
            if (busy)       cells[sweep_ptr] <= BLANK;
            else if (wr_en) cells[wr_addr]   <= cells[wr_addr] & wr_mask;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
    import otp_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  otp_mode_e         mode,
    input  logic              ce_n,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] din,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_mask
);
    logic armed;
    logic in_pulse;

    assign in_pulse = (mode == M_PROGRAM) && !busy;

    // Address and data are held from the last cycle of the low pulse.
    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            wr_addr <= '0;
            wr_mask <= '1;
        end else begin
            armed <= in_pulse;
            if (in_pulse) begin
                wr_addr <= addr;
                wr_mask <= din;
            end
        end
    end

    // Commit on the select rising edge with the voltage still on and the gate high.
    assign wr_en = armed && !busy && ce_n && (mode == M_INHIBIT);

endmodule

// File: rtl/otp_eprom_model.sv
module otp_eprom_model
    import otp_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_on,
    input  logic              a9_hv,
    input  logic              erase,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en
);
    otp_mode_e         mode;
    logic              sweep_busy;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [WORD_W-1:0] wr_mask;
    logic [WORD_W-1:0] rd_data;
    otp_drive_t        drive_d;
    otp_drive_t        drive_q;

    assign mode = decode_mode(ce_n, oe_n, vpp_on, a9_hv);

    otp_prog_ctrl #(.ADDR_W(ADDR_W)) u_prog (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .ce_n    (ce_n),
        .busy    (sweep_busy),
        .addr    (addr),
        .din     (din),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_mask (wr_mask)
    );

    otp_cell_array #(.ADDR_W(ADDR_W)) u_array (
        .clk       (clk),
        .rst       (rst),
        .erase_req (erase),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_mask   (wr_mask),
        .rd_addr   (addr),
        .rd_data   (rd_data),
        .busy      (sweep_busy)
    );

    always_comb begin
        drive_d = '0;
        if (!sweep_busy) begin
            unique case (mode)
                M_READ, M_VERIFY: drive_d = '{en: 1'b1, data: rd_data};
                M_IDENT:          drive_d = '{en: 1'b1, data: ident_byte(addr[0])};
                default:          drive_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) drive_q <= '0;
        else     drive_q <= drive_d;
    end

    assign dout    = drive_q.data;
    assign dout_en = drive_q.en;

endmodule

// File: rtl/otp_eprom_model_chk.sv
module otp_eprom_model_chk #(
    parameter int unsigned ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              ce_n,
    input logic              oe_n,
    input logic              vpp_on,
    input logic              a9_hv,
    input logic [7:0]        dout,
    input logic              dout_en,
    input logic              busy
);
    p_off_undriven_r2: assert property (@(posedge clk) disable iff (rst)
        (!vpp_on && !ce_n && oe_n) |=> !dout_en);

    p_standby_undriven_r3: assert property (@(posedge clk) disable iff (rst)
        (!vpp_on && ce_n) |=> !dout_en);

    p_idle_bus_zero_r4: assert property (@(posedge clk) disable iff (rst)
        !dout_en |-> (dout == 8'h00));

    p_prog_inhibit_undriven_r8: assert property (@(posedge clk) disable iff (rst)
        (vpp_on && oe_n) |=> !dout_en);

    p_ident_byte_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && a9_hv && !vpp_on && !ce_n && !oe_n) |=>
            (dout_en && (dout == ($past(addr[0]) ? 8'h8D : 8'h20))));

    p_sweep_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> !dout_en);

endmodule

bind otp_eprom_model otp_eprom_model_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .vpp_on  (vpp_on),
    .a9_hv   (a9_hv),
    .dout    (dout),
    .dout_en (dout_en),
    .busy    (sweep_busy)
);

// File: tb/otp_eprom_model_bench.sv
module otp_eprom_model_bench;
    localparam int unsigned ADDR_W = 11;
    localparam int unsigned DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              ce_n = 1'b1, oe_n = 1'b1, vpp_on = 1'b0, a9_hv = 1'b0, erase = 1'b0;
    logic [7:0]        din = '0;
    logic [7:0]        dout;
    logic              dout_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic       en;
        logic [7:0] data;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    exp_t       got;
    logic [7:0] model [DEPTH];

    always #5 clk = ~clk;

    otp_eprom_model #(.ADDR_W(ADDR_W)) u_otp_eprom_model (
        .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
        .vpp_on(vpp_on), .a9_hv(a9_hv), .erase(erase), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    // Monitor: each expectation is consumed just after the edge that produces it.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            got = exp_q.pop_front();
            checks++;
            if (dout_en !== got.en || (got.en && dout !== got.data) || (!got.en && dout !== 8'h00)) begin
                failures++;
                $display("FAIL %s: got en=%0b data=%02h, expected en=%0b data=%02h",
                         got.tag, dout_en, dout, got.en, got.en ? got.data : 8'h00);
            end
        end
    end

    task automatic step(input logic c, input logic o, input logic v, input logic h,
                        input logic e, input logic [ADDR_W-1:0] a, input logic [7:0] d,
                        input bit chk, input logic x_en, input logic [7:0] x_data,
                        input string tag);
        exp_t item;
        @(negedge clk);
        ce_n = c; oe_n = o; vpp_on = v; a9_hv = h; erase = e; addr = a; din = d;
        if (chk) begin
            item.en = x_en; item.data = x_data; item.tag = tag;
            exp_q.push_back(item);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1, 1, 0, 0, 0, '0, '0, 0, 0, '0, "");
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
        step(0, 0, 0, 0, 0, a, '0, 1, 1, model[a], tag);
    endtask

    task automatic prog(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        step(0, 1, 1, 0, 0, a, d, 1, 0, '0, "R8 program pulse undriven");
        step(1, 1, 1, 0, 0, a, d, 1, 0, '0, "R8 inhibit undriven");
        model[a] = model[a] & d;
    endtask

    task automatic blank_model();
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    endtask

    initial begin
        blank_model();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11/R10: sweep after reset keeps the bus quiet; R4 zero bus.
        step(0, 0, 0, 0, 0, 11'd0, '0, 1, 0, '0, "R11 read during reset sweep");
        step(0, 0, 0, 0, 0, 11'd3, '0, 1, 0, '0, "R4 bus zero while sweeping");
        idle(DEPTH + 4);
        rd(11'd0, "R11 blank word 0");
        rd(11'd5, "R11 blank word 5");
        rd(11'(DEPTH - 1), "R11 blank last word");

        // R5 and R7: program then verify, second program only clears bits.
        prog(11'd5, 8'hA5);
        step(1, 0, 1, 0, 0, 11'd5, '0, 1, 1, 8'hA5, "R7 verify after program");
        prog(11'd5, 8'h5A);
        step(1, 0, 1, 0, 0, 11'd5, '0, 1, 1, 8'h00, "R5 AND of A5 and 5A");
        prog(11'd7, 8'hF0);
        prog(11'd7, 8'hCF);
        step(1, 0, 1, 0, 0, 11'd7, '0, 1, 1, 8'hC0, "R5 AND of F0 and CF");
        prog(11'd8, 8'hFF);
        rd(11'd8, "R5 program of all ones keeps FF");

        // R1, R2, R3.
        rd(11'd7, "R1 read word 7");
        rd(11'd5, "R1 read word 5");
        step(0, 1, 0, 0, 0, 11'd7, '0, 1, 0, '0, "R2 output off");
        step(1, 0, 0, 0, 0, 11'd7, '0, 1, 0, '0, "R3 standby gate low");
        step(1, 1, 0, 0, 0, 11'd7, '0, 1, 0, '0, "R3 standby gate high");

        // R6: aborted pulses.
        step(0, 1, 1, 0, 0, 11'd9, 8'h00, 0, 0, '0, "");
        step(0, 1, 0, 0, 0, 11'd9, 8'h00, 0, 0, '0, "");
        step(1, 1, 0, 0, 0, 11'd9, 8'h00, 0, 0, '0, "");
        rd(11'd9, "R6 voltage drop aborts program");
        step(0, 1, 1, 0, 0, 11'd9, 8'h00, 0, 0, '0, "");
        step(0, 0, 1, 0, 0, 11'd9, 8'h00, 1, 0, '0, "R8 both strobes low with voltage");
        step(1, 1, 1, 0, 0, 11'd9, 8'h00, 0, 0, '0, "");
        rd(11'd9, "R6 gate low aborts program");

        // R9: identifier bytes.
        step(0, 0, 0, 1, 0, 11'd0, '0, 1, 1, 8'h20, "R9 maker byte");
        step(0, 0, 0, 1, 0, 11'd1, '0, 1, 1, 8'h8D, "R9 part byte");
        step(1, 0, 0, 1, 0, 11'd1, '0, 1, 0, '0, "R9 no ident in standby");

        // R10: erase sweep, accesses ignored while it runs.
        step(1, 1, 0, 0, 1, '0, '0, 0, 0, '0, "");
        step(0, 0, 0, 0, 0, 11'd5, '0, 1, 0, '0, "R10 read ignored during erase");
        idle(100);
        step(0, 1, 1, 0, 0, 11'd0, 8'h00, 1, 0, '0, "R10 pulse during erase");
        step(1, 1, 1, 0, 0, 11'd0, 8'h00, 1, 0, '0, "R10 pulse during erase");
        step(1, 0, 1, 0, 0, 11'd0, '0, 1, 0, '0, "R10 verify ignored during erase");
        idle(DEPTH + 4);
        blank_model();
        rd(11'd0, "R10 program during sweep ignored");
        rd(11'd5, "R10 word 5 blank after erase");
        rd(11'd7, "R10 word 7 blank after erase");
        rd(11'(DEPTH - 1), "R10 last word blank after erase");
        idle(3);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired before the end of the scenarios");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule